// File: doc/BRIEF.md
# Pixel Clock Synthesizer Reprogramming Sequencer

This block changes the setting of a pixel-clock synthesizer without letting it lock onto a half-written setting. It sits in front of the synthesizer's 32-bit control word. The word is reached through a simple request/acknowledge register port that has one read-back path. A start pulse latches a new divider word. The sequencer then reads the current control word once. Next it performs five cumulative writes: it parks the synthesizer in reset and bypass, merges in the new divider word, waits a settling time, turns the synthesizer on, releases reset and finally removes bypass.

Each write is built from the word written just before it, so bits that the sequence does not touch keep their read-back values. The settling wait is a parameter in clock cycles, normally one millisecond of the system clock. It starts only after the merge write has been acknowledged. `busy_o` covers the whole sequence, and `done_o` marks its last cycle.

Top module: `pclk_reprog_seq`

## Requirements
- R1: While reset is asserted and after its release, `busy_o`, `done_o` and `bus_req_o` are low.
- R2: A `start_i` pulse while idle latches `cfg_word_i`. On the next cycle `busy_o` and `bus_req_o` rise with `bus_we_o` low, so the first transfer is a read.
- R3: The first write carries the read-back word with bit 5 cleared and with bit 31 (reset) and bit 8 (bypass) set.
- R4: The second write is the first write's word ORed with the latched configuration word, after bits 31, 11, 8 and 5 of the configuration word have been forced to zero.
- R5: After the second write is acknowledged, `bus_req_o` stays low for exactly `SETTLE_CYCLES` cycles. The third request follows at once.
- R6: The third write is the second write's word with bit 11 (enable) set.
- R7: The fourth write is the third write's word with bit 31 cleared.
- R8: The fifth write is the fourth write's word with bit 8 cleared. A sequence consists of exactly one read followed by five writes.
- R9: A request holds `bus_req_o`, `bus_we_o` and `bus_wdata_o` steady until the cycle in which `bus_ack_i` is sampled high.
- R10: `busy_o` stays high from the cycle after an accepted start through the cycle of `done_o`. `done_o` is a single-cycle pulse that comes one cycle after the fifth acknowledge, and `busy_o` is low in the following cycle.
- R11: A `start_i` pulse while `busy_o` is high, including the `done_o` cycle, has no effect. Changes on `cfg_word_i` after the accepted start have no effect either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a reprogramming sequence (taken only when idle) |
| cfg_word_i | input | DATA_W | New synthesizer configuration word |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_wdata_o | output | DATA_W | Write data |
| bus_rdata_i | input | DATA_W | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Access acknowledge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can land in the same cycle: a new start request and the completion cycle in which `done_o` is high. The bench raises `start_i` exactly in the `done_o` cycle. After that cycle it expects `busy_o` to fall and no new read to appear for several cycles. It also pulses start during the settling wait and changes `cfg_word_i` right after each accepted start. In both cases it judges the six transfers against words computed from the original configuration word. The register slave acknowledges after random delays, which exercises the hold rule on every request.

// File: rtl/pclk_seq_pkg.sv
package pclk_seq_pkg;

  localparam int unsigned RST_BIT  = 31;
  localparam int unsigned EN_BIT   = 11;
  localparam int unsigned BYP_BIT  = 8;
  localparam int unsigned CLR_BIT  = 5;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_READ,
    ST_WR_PARK,
    ST_WR_MERGE,
    ST_SETTLE,
    ST_WR_ENABLE,
    ST_WR_UNRESET,
    ST_WR_UNBYPASS,
    ST_FIN
  } seq_state_e;

endpackage

// File: rtl/pclk_settle_timer.sv
module pclk_settle_timer #(
  parameter int unsigned CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = CNT_W'(CYCLES - 1);
    end else if (run_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = run_i && (cnt_q == '0);

endmodule

// File: rtl/pclk_word_merge.sv
module pclk_word_merge
  import pclk_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  seq_state_e        state_i,
  input  logic [DATA_W-1:0] rd_word_i,
  input  logic [DATA_W-1:0] cur_word_i,
  input  logic [DATA_W-1:0] cfg_word_i,
  output logic [DATA_W-1:0] nxt_word_o
);
  localparam logic [DATA_W-1:0] M_RST = DATA_W'(1) << RST_BIT;
  localparam logic [DATA_W-1:0] M_EN  = DATA_W'(1) << EN_BIT;
  localparam logic [DATA_W-1:0] M_BYP = DATA_W'(1) << BYP_BIT;
  localparam logic [DATA_W-1:0] M_CLR = DATA_W'(1) << CLR_BIT;
  localparam logic [DATA_W-1:0] M_CFG = ~(M_RST | M_EN | M_BYP | M_CLR);

  // The word produced here is the one written in the state being entered.
  always_comb begin
    unique case (state_i)
      ST_READ:       nxt_word_o = (rd_word_i & ~M_CLR) | M_RST | M_BYP;
      ST_WR_PARK:    nxt_word_o = cur_word_i | (cfg_word_i & M_CFG);
      ST_SETTLE:     nxt_word_o = cur_word_i | M_EN;
      ST_WR_ENABLE:  nxt_word_o = cur_word_i & ~M_RST;
      ST_WR_UNRESET: nxt_word_o = cur_word_i & ~M_BYP;
      default:       nxt_word_o = cur_word_i;
    endcase
  end

endmodule

// File: rtl/pclk_reprog_seq.sv
module pclk_reprog_seq
  import pclk_seq_pkg::*;
#(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned SETTLE_CYCLES = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] cfg_word_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ack_i,
  output logic              busy_o,
  output logic              done_o
);

  seq_state_e        state_q, state_d;
  logic [DATA_W-1:0] cfg_q;
  logic [DATA_W-1:0] word_q, word_nxt;
  logic              accept, access, step, settle_done;

  assign access = (state_q == ST_READ)      || (state_q == ST_WR_PARK)   ||
                  (state_q == ST_WR_MERGE)  || (state_q == ST_WR_ENABLE) ||
                  (state_q == ST_WR_UNRESET)|| (state_q == ST_WR_UNBYPASS);
  assign accept = (state_q == ST_IDLE) && start_i;
  assign step   = (access && bus_ack_i) || settle_done;

  pclk_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    ((state_q == ST_WR_MERGE) && bus_ack_i),
    .run_i     (state_q == ST_SETTLE),
    .expired_o (settle_done)
  );

  pclk_word_merge #(.DATA_W(DATA_W)) u_merge (
    .state_i    (state_q),
    .rd_word_i  (bus_rdata_i),
    .cur_word_i (word_q),
    .cfg_word_i (cfg_q),
    .nxt_word_o (word_nxt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:        if (start_i)     state_d = ST_READ;
      ST_READ:        if (bus_ack_i)   state_d = ST_WR_PARK;
      ST_WR_PARK:     if (bus_ack_i)   state_d = ST_WR_MERGE;
      ST_WR_MERGE:    if (bus_ack_i)   state_d = ST_SETTLE;
      ST_SETTLE:      if (settle_done) state_d = ST_WR_ENABLE;
      ST_WR_ENABLE:   if (bus_ack_i)   state_d = ST_WR_UNRESET;
      ST_WR_UNRESET:  if (bus_ack_i)   state_d = ST_WR_UNBYPASS;
      ST_WR_UNBYPASS: if (bus_ack_i)   state_d = ST_FIN;
      ST_FIN:                          state_d = ST_IDLE;
      default:                         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (accept) cfg_q <= cfg_word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (step) word_q <= word_nxt;
  end

  assign bus_req_o   = access;
  assign bus_we_o    = access && (state_q != ST_READ);
  assign bus_wdata_o = word_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FIN);

endmodule

// File: rtl/pclk_reprog_seq_chk.sv
module pclk_reprog_seq_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_ack_i,
  input logic              busy_o,
  input logic              done_o
);

  AST_START_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && bus_req_o && !bus_we_o)); // R2

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_we_o) && $stable(bus_wdata_o))); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

  AST_DONE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o); // R10

  AST_REQ_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> busy_o); // R10

  AST_START_AT_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!bus_req_o && !done_o)); // R1

endmodule

bind pclk_reprog_seq pclk_reprog_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ack_i   (bus_ack_i),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/pclk_reprog_seq_bench.sv
module pclk_reprog_seq_bench;
  localparam int N = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] cfg_i;
  logic        req, we, ack, busy, done;
  logic [31:0] wdata, rd_val;

  always #5 clk = ~clk;

  pclk_reprog_seq #(.DATA_W(32), .SETTLE_CYCLES(N)) u_pclk_reprog_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_word_i(cfg_i),
    .bus_req_o(req), .bus_we_o(we), .bus_wdata_o(wdata),
    .bus_rdata_i(rd_val), .bus_ack_i(ack), .busy_o(busy), .done_o(done));

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] log_d [0:7];
  logic        log_we [0:7];
  int          log_n, settle_n, done_n, wt;
  bit          clr, first_seen;
  logic        snap_we;
  logic [31:0] snap_d;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int k, input logic [31:0] rd, input logic [31:0] cfg);
    logic [31:0] w;
    w = (rd & ~32'h0000_0020) | 32'h8000_0100;
    if (k >= 2) w = w | (cfg & ~32'h8000_0920);
    if (k >= 3) w = w | 32'h0000_0800;
    if (k >= 4) w = w & ~32'h8000_0000;
    if (k >= 5) w = w & ~32'h0000_0100;
    return w;
  endfunction

  // register slave with random acknowledge delay, plus monitors
  always @(negedge clk) begin
    if (clr) begin
      log_n = 0; settle_n = 0; done_n = 0;
    end
    if (!rst_n) begin
      ack = 1'b0; wt = 0; first_seen = 1'b0;
    end else if (ack) begin
      ack = 1'b0;
      wt  = int'($urandom_range(0, 3));
    end else if (req) begin
      if (!first_seen) begin
        snap_we = we; snap_d = wdata; first_seen = 1'b1;
      end
      if (wt == 0) begin
        chk(we == snap_we && wdata == snap_d, "R9 hold", wdata, snap_d);
        if (log_n < 8) begin
          log_d[log_n] = wdata; log_we[log_n] = we;
        end
        log_n++;
        ack = 1'b1;
        first_seen = 1'b0;
      end else wt--;
    end
    if (rst_n && busy && !req && !done) settle_n++;
    if (rst_n && done) done_n++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog actual=%0d expected=<150000", cyc);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic run_seq(input logic [31:0] cfg, input logic [31:0] rd,
                         input bit poke_busy, input bit poke_done);
    int k;
    @(posedge clk); #1 clr = 1'b1; rd_val = rd;
    @(negedge clk); #1 clr = 1'b0;
    start_i = 1'b1; cfg_i = cfg;
    @(negedge clk);
    start_i = 1'b0; cfg_i = ~cfg;               // R11 late change
    chk(busy && req && !we, "R2 start", {29'd0, busy, req, we}, 32'h6);
    k = 0;
    while (!done) begin
      @(negedge clk);
      k++;
      if (poke_busy && k == 12) begin start_i = 1'b1; cfg_i = 32'h1234_5678; end
      else start_i = 1'b0;
      if (!done) chk(busy, "R10 busy held", {31'd0, busy}, 32'd1);
    end
    if (poke_done) start_i = 1'b1;              // start in the done cycle
    @(negedge clk);
    start_i = 1'b0;
    chk(!busy && !done, "R10 busy falls after done", {30'd0, busy, done}, 32'd0);
    repeat (4) @(negedge clk);
    chk(!busy && log_n == 6, "R11 no restart", log_n, 32'd6);
    chk(done_n == 1, "R10 single done", done_n, 32'd1);
    chk(settle_n == N, "R5 settle gap", settle_n, N);
    chk(log_we[0] == 1'b0, "R2 read first", {31'd0, log_we[0]}, 32'd0);
    for (int i = 1; i <= 5; i++) begin
      chk(log_we[i] == 1'b1, "R8 write kind", {31'd0, log_we[i]}, 32'd1);
      case (i)
        1: chk(log_d[i] == exp_word(1, rd, cfg), "R3 park write", log_d[i], exp_word(1, rd, cfg));
        2: chk(log_d[i] == exp_word(2, rd, cfg), "R4 merge write", log_d[i], exp_word(2, rd, cfg));
        3: chk(log_d[i] == exp_word(3, rd, cfg), "R6 enable write", log_d[i], exp_word(3, rd, cfg));
        4: chk(log_d[i] == exp_word(4, rd, cfg), "R7 unreset write", log_d[i], exp_word(4, rd, cfg));
        default: chk(log_d[i] == exp_word(5, rd, cfg), "R8 unbypass write", log_d[i], exp_word(5, rd, cfg));
      endcase
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start_i = 1'b0; cfg_i = '0; rd_val = '0; clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !req, "R1 in reset", {29'd0, busy, done, req}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !req, "R1 after reset", {29'd0, busy, done, req}, 32'd0);
    run_seq(32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0);
    run_seq(32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0);
    run_seq(32'h33915801, 32'h8000_0920, 1'b1, 1'b0);
    run_seq(32'h2710C805, 32'h0000_0120, 1'b0, 1'b1);
    for (int r = 0; r < 6; r++)
      run_seq($urandom, $urandom, r == 2, r == 4);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule